// File: doc/BRIEF.md
# Sleep and Wake-Up Controller

This block manages the low-power state of a small microcontroller core. When the instruction decoder reports that a sleep instruction has executed, the controller drops the core clock enable. It then watches for a wake event: the external reset input, a watchdog expiry while the watchdog is enabled, or any interrupt source whose flag and enable are both set. A watchdog or interrupt wake resumes program execution after an oscillator start-up wait. That wait is long in crystal mode and a few cycles in internal RC mode. The external reset returns the core to its running state at once, so that the reset sequence elsewhere in the chip can take over.

Two status flags record why the core is running. The power-down flag is set by power-on reset and cleared by entering sleep. The timeout flag is set by power-on reset and by entering sleep, and cleared by a watchdog wake. Every wake also produces a one-cycle clear pulse for the watchdog counter. The global interrupt enable does not affect whether the core wakes. After an interrupt wake it decides only one thing: either the core runs on from the prefetched instruction, or it gets a one-cycle vector request once that instruction retires.

Top module: `slp_ctrl`

## Requirements
- R1: After synchronous reset, core_ce_o is 1, pd_o is 1, to_o is 1, and wake_o, vec_req_o and wdt_clr_o are 0.
- R2: A sleep_req_i pulse while running makes core_ce_o 0 from the next cycle, with pd_o at 0 and to_o at 1.
- R3: While asleep, the core wakes in any cycle where some bit i has irq_flag_i[i] and irq_en_i[i] both at 1, whatever gie_i is. A flag without its enable, or an enable without its flag, never wakes it.
- R4: A watchdog expiry wakes the core only while wdt_en_i is 1, and it drives to_o to 0 from the next cycle. When the watchdog and an interrupt fire in the same cycle, the watchdog is taken as the cause.
- R5: wdt_clr_o is 1 in exactly the sleeping cycle in which a wake is seen, from any of the three sources, and 0 in every other cycle.
- R6: If an enabled interrupt is already pending when the sleep request arrives, the sleep still takes effect (pd_o goes to 0) and the wake is seen in the first sleeping cycle.
- R7: After the wake cycle, core_ce_o stays 0 for exactly OST_CYCLES cycles when rc_mode_i is 0, or exactly RC_CYCLES cycles when rc_mode_i is 1. rc_mode_i is sampled in the wake cycle.
- R8: wake_o is a one-cycle pulse in the first cycle that core_ce_o is 1 again after a watchdog or interrupt wake.
- R9: After an interrupt wake with gie_i at 1 at the end of start-up, vec_req_o is 1 for one cycle, in the cycle after retire_i is seen. After a watchdog wake, or an interrupt wake with gie_i at 0, vec_req_o stays 0.
- R10: ext_rst_i while asleep or in start-up makes core_ce_o 1 from the next cycle. It gives no wake_o pulse and no vector request, and it leaves pd_o and to_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| sleep_req_i | input | 1 | Sleep instruction executed (one cycle) |
| irq_flag_i | input | N_IRQ | Interrupt request flags |
| irq_en_i | input | N_IRQ | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| wdt_en_i | input | 1 | Watchdog enabled |
| wdt_expire_i | input | 1 | Watchdog timeout |
| ext_rst_i | input | 1 | External reset pin |
| rc_mode_i | input | 1 | 1 = internal RC oscillator, short start-up |
| retire_i | input | 1 | Prefetched instruction retired |
| core_ce_o | output | 1 | Core clock enable |
| wake_o | output | 1 | One-cycle resume pulse |
| vec_req_o | output | 1 | One-cycle interrupt vector request |
| wdt_clr_o | output | 1 | Watchdog counter clear |
| pd_o | output | 1 | Power-down status flag |
| to_o | output | 1 | Timeout status flag |

## Verification
A watchdog expiry and an enabled interrupt can arrive in the same sleeping cycle. The bench raises both in that cycle, with the global enable set. The result is judged correct when the timeout flag falls and no vector request follows the retire pulse, because the watchdog outranks the interrupt. A second collision is an immediate wake at sleep entry. Here the power-down flag must still fall, and the watchdog clear must appear in the first sleeping cycle.

// File: rtl/slp_pkg.sv
package slp_pkg;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SLEEP,
        ST_START,
        ST_PEND
    } slp_state_e;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_RESET,
        WK_WDOG,
        WK_IRQ
    } wake_src_e;

    typedef struct packed {
        logic      hit;
        wake_src_e src;
    } wake_evt_t;

    // Highest priority first: reset pin, watchdog, interrupt
    function automatic wake_src_e pick_src(logic pin_rst, logic wdog, logic irq);
        if (pin_rst)   return WK_RESET;
        else if (wdog) return WK_WDOG;
        else if (irq)  return WK_IRQ;
        else           return WK_NONE;
    endfunction

endpackage

// File: rtl/slp_wake_detect.sv
module slp_wake_detect
    import slp_pkg::*;
#(
    parameter int N_IRQ = 4
) (
    input  logic             ext_rst_i,
    input  logic             wdt_en_i,
    input  logic             wdt_expire_i,
    input  logic [N_IRQ-1:0] irq_flag_i,
    input  logic [N_IRQ-1:0] irq_en_i,
    output wake_evt_t        evt_o
);

    logic [N_IRQ-1:0] armed;
    logic             any_irq;
    logic             wdog_hit;

    always_comb begin
        armed      = irq_flag_i & irq_en_i;
        any_irq    = |armed;
        wdog_hit   = wdt_en_i & wdt_expire_i;
        evt_o.src  = pick_src(ext_rst_i, wdog_hit, any_irq);
        evt_o.hit  = (evt_o.src != WK_NONE);
    end

endmodule

// File: rtl/slp_ost_timer.sv
module slp_ost_timer #(
    parameter int OST_CYCLES = 1024,
    parameter int RC_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    input  logic rc_mode_i,
    input  logic abort_i,
    output logic busy_o,
    output logic done_o
);

    localparam int MAXC = (OST_CYCLES > RC_CYCLES) ? OST_CYCLES : RC_CYCLES;
    localparam int CW   = $clog2(MAXC) + 1;
    localparam logic [CW-1:0] OST_LD = CW'(OST_CYCLES - 1);
    localparam logic [CW-1:0] RC_LD  = CW'(RC_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign done_o = busy_o && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            busy_o <= 1'b0;
            cnt    <= '0;
        end else if (load_i) begin
            busy_o <= 1'b1;
            cnt    <= rc_mode_i ? RC_LD : OST_LD;
        end else if (busy_o) begin
            if (cnt == '0) busy_o <= 1'b0;
            else           cnt    <= cnt - 1'b1;
        end
    end

    // R7
    load_starts_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && !abort_i) |=> busy_o);

endmodule

// File: rtl/slp_status_flags.sv
module slp_status_flags (
    input  logic clk,
    input  logic rst,
    input  logic sleep_ent_i,
    input  logic wdog_wake_i,
    output logic pd_o,
    output logic to_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_o <= 1'b1;
            to_o <= 1'b1;
        end else if (sleep_ent_i) begin
            pd_o <= 1'b0;
            to_o <= 1'b1;
        end else if (wdog_wake_i) begin
            to_o <= 1'b0;
        end
    end

    // R2
    sleep_flags_chk: assert property (@(posedge clk) disable iff (rst)
        sleep_ent_i |=> (!pd_o && to_o));

    // R4
    wdog_to_chk: assert property (@(posedge clk) disable iff (rst)
        wdog_wake_i |=> !to_o);

endmodule

// File: rtl/slp_ctrl.sv
module slp_ctrl
    import slp_pkg::*;
#(
    parameter int N_IRQ      = 4,
    parameter int OST_CYCLES = 1024,
    parameter int RC_CYCLES  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sleep_req_i,
    input  logic [N_IRQ-1:0] irq_flag_i,
    input  logic [N_IRQ-1:0] irq_en_i,
    input  logic             gie_i,
    input  logic             wdt_en_i,
    input  logic             wdt_expire_i,
    input  logic             ext_rst_i,
    input  logic             rc_mode_i,
    input  logic             retire_i,
    output logic             core_ce_o,
    output logic             wake_o,
    output logic             vec_req_o,
    output logic             wdt_clr_o,
    output logic             pd_o,
    output logic             to_o
);

    slp_state_e state, state_nx;
    wake_evt_t  evt;
    logic       cause_irq;
    logic       sleep_ent, in_sleep, wake_go, wdog_wake;
    logic       ost_busy, ost_done, pin_abort;

    slp_wake_detect #(.N_IRQ(N_IRQ)) u_det (
        .ext_rst_i    (ext_rst_i),
        .wdt_en_i     (wdt_en_i),
        .wdt_expire_i (wdt_expire_i),
        .irq_flag_i   (irq_flag_i),
        .irq_en_i     (irq_en_i),
        .evt_o        (evt)
    );

    assign in_sleep  = (state == ST_SLEEP);
    assign sleep_ent = (state == ST_RUN) && sleep_req_i && !ext_rst_i;
    assign wake_go   = in_sleep && evt.hit && (evt.src != WK_RESET);
    assign wdog_wake = wake_go && (evt.src == WK_WDOG);
    assign pin_abort = ext_rst_i && (state != ST_RUN);
    assign wdt_clr_o = in_sleep && evt.hit;
    assign core_ce_o = (state == ST_RUN) || (state == ST_PEND);

    slp_ost_timer #(.OST_CYCLES(OST_CYCLES), .RC_CYCLES(RC_CYCLES)) u_ost (
        .clk       (clk),
        .rst       (rst),
        .load_i    (wake_go),
        .rc_mode_i (rc_mode_i),
        .abort_i   (pin_abort),
        .busy_o    (ost_busy),
        .done_o    (ost_done)
    );

    slp_status_flags u_flags (
        .clk         (clk),
        .rst         (rst),
        .sleep_ent_i (sleep_ent),
        .wdog_wake_i (wdog_wake),
        .pd_o        (pd_o),
        .to_o        (to_o)
    );

    always_comb begin
        state_nx = state;
        case (state)
            ST_RUN:   if (sleep_ent) state_nx = ST_SLEEP;
            ST_SLEEP: if (wake_go)   state_nx = ST_START;
            ST_START: if (ost_done)  state_nx = (cause_irq && gie_i) ? ST_PEND : ST_RUN;
            ST_PEND:  if (retire_i)  state_nx = ST_RUN;
            default:                 state_nx = ST_RUN;
        endcase
        if (ext_rst_i) state_nx = ST_RUN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RUN;
            cause_irq <= 1'b0;
            wake_o    <= 1'b0;
            vec_req_o <= 1'b0;
        end else begin
            state     <= state_nx;
            if (wake_go) cause_irq <= (evt.src == WK_IRQ);
            wake_o    <= (state == ST_START) && ost_done && !ext_rst_i;
            vec_req_o <= (state == ST_PEND) && retire_i && !ext_rst_i;
        end
    end

    // R8
    wake_resume_chk: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> (core_ce_o && !$past(core_ce_o)));

    // R8
    wake_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake_o |=> !wake_o);

    // R9
    vec_after_retire_chk: assert property (@(posedge clk) disable iff (rst)
        vec_req_o |-> $past(retire_i));

    // R9
    vec_single_chk: assert property (@(posedge clk) disable iff (rst)
        vec_req_o |=> !vec_req_o);

    // R7
    timer_gates_core_chk: assert property (@(posedge clk) disable iff (rst)
        ost_busy |-> !core_ce_o);

    // R10
    pin_reset_run_chk: assert property (@(posedge clk) disable iff (rst)
        ext_rst_i |=> (core_ce_o && !wake_o && !vec_req_o));

endmodule

// File: tb/slp_ctrl_tb_top.sv
module slp_ctrl_tb_top;

    localparam int NI  = 3;
    localparam int OST = 24;
    localparam int RC  = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sleep_req = 1'b0;
    logic [NI-1:0] irq_flag = '0;
    logic [NI-1:0] irq_en = '0;
    logic          gie = 1'b0, wdt_en = 1'b0, wdt_exp = 1'b0;
    logic          ext_rst = 1'b0, rc_mode = 1'b0, retire = 1'b0;
    logic          core_ce, wake, vec_req, wdt_clr, pd, to;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    slp_ctrl #(.N_IRQ(NI), .OST_CYCLES(OST), .RC_CYCLES(RC)) dut_i (
        .clk(clk), .rst(rst), .sleep_req_i(sleep_req), .irq_flag_i(irq_flag),
        .irq_en_i(irq_en), .gie_i(gie), .wdt_en_i(wdt_en), .wdt_expire_i(wdt_exp),
        .ext_rst_i(ext_rst), .rc_mode_i(rc_mode), .retire_i(retire),
        .core_ce_o(core_ce), .wake_o(wake), .vec_req_o(vec_req),
        .wdt_clr_o(wdt_clr), .pd_o(pd), .to_o(to)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One sleep/wake round; both = watchdog and interrupt in the same cycle
    task automatic run_case(logic [NI-1:0] f, logic [NI-1:0] e, bit g, bit r, bit both);
        bit imm, by_wdog, want_vec;
        int dly, n;
        irq_flag = f; irq_en = e; gie = g; rc_mode = r;
        imm = |(f & e);
        by_wdog = !imm || both;
        wdt_en = both; wdt_exp = both;
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        chk("R2 core_ce after sleep", core_ce, 0);
        chk("R2 pd after sleep", pd, 0);
        chk("R2 to after sleep", to, 1);
        if (imm) begin
            chk("R6 immediate wake clear", wdt_clr, 1);
        end else begin
            for (int k = 0; k < 3; k++) begin
                wdt_en = 1'b0; wdt_exp = (k == 1);
                #0;
                chk("R3 no wake without enable match", wdt_clr, 0);
                chk("R4 disabled watchdog ignored", wdt_clr, 0);
                step();
                chk("R3 still asleep", core_ce, 0);
            end
            wdt_en = 1'b1; wdt_exp = 1'b1;
            #1;
            chk("R5 wdt clear on watchdog wake", wdt_clr, 1);
        end
        step();
        wdt_exp = 1'b0; wdt_en = 1'b0; irq_flag = '0;
        dly = r ? RC : OST;
        n = 0;
        while (!core_ce && n < 200) begin
            chk("R5 clear only in wake cycle", wdt_clr, 0);
            n++;
            step();
        end
        chk("R7 start-up length", n, dly);
        chk("R8 wake pulse", wake, 1);
        chk("R4 timeout flag", to, by_wdog ? 0 : 1);
        want_vec = !by_wdog && g;
        step();
        chk("R8 wake pulse one cycle", wake, 0);
        chk("R9 no vector before retire", vec_req, 0);
        retire = 1'b1;
        step();
        retire = 1'b0;
        chk("R9 vector after retire", vec_req, want_vec ? 1 : 0);
        step();
        chk("R9 vector one cycle", vec_req, 0);
        chk("R2 core running", core_ce, 1);
    endtask

    initial begin
        step();
        step();
        chk("R1 core_ce", core_ce, 1);
        chk("R1 pd", pd, 1);
        chk("R1 to", to, 1);
        chk("R1 wake", wake, 0);
        chk("R1 vec", vec_req, 0);
        rst = 1'b0;
        step();
        chk("R1 wdt_clr", wdt_clr, 0);
        chk("R1 still running", core_ce, 1);

        for (int f = 0; f < (1 << NI); f++)
            for (int e = 0; e < (1 << NI); e++)
                for (int g = 0; g < 2; g++)
                    for (int r = 0; r < 2; r++)
                        run_case(NI'(f), NI'(e), g[0], r[0], 1'b0);

        // R4 watchdog and interrupt collide; R9 no vector then
        run_case(3'b010, 3'b010, 1'b1, 1'b1, 1'b1);
        run_case(3'b111, 3'b100, 1'b1, 1'b0, 1'b1);

        // R10 pin reset during start-up
        wdt_en = 1'b1; wdt_exp = 1'b1; sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        step();
        wdt_exp = 1'b0; wdt_en = 1'b0;
        step();
        chk("R10 in start-up", core_ce, 0);
        ext_rst = 1'b1;
        step();
        ext_rst = 1'b0;
        chk("R10 core released", core_ce, 1);
        chk("R10 no wake pulse", wake, 0);
        chk("R10 pd kept", pd, 0);
        chk("R10 to kept", to, 0);
        for (int k = 0; k < OST + 2; k++) begin
            step();
            chk("R10 no later wake pulse", wake + vec_req, 0);
        end

        // R10 pin reset while sleeping, R5 clear on that wake
        sleep_req = 1'b1;
        step();
        sleep_req = 1'b0;
        step();
        chk("R10 asleep", core_ce, 0);
        ext_rst = 1'b1;
        #1;
        chk("R5 clear on pin reset", wdt_clr, 1);
        step();
        ext_rst = 1'b0;
        chk("R10 running after pin", core_ce, 1);
        chk("R10 no wake after pin", wake, 0);
        chk("R10 to kept at 1", to, 1);
        chk("R10 pd kept at 0", pd, 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule